// File: doc/BRIEF.md
# Multi-Segment I2C Transaction Sequencer

This block runs a complete I2C transaction, made of up to 2^SEG_W message segments, on top of a byte-level bus engine. No processor is needed for each byte. The engine is modelled as two handshakes: a command handshake that carries one byte and its bus flags out, and an event pulse that returns the outcome of that byte. For every byte the sequencer decides four things: whether the byte goes out with START, whether it is sent or received, whether STOP follows it, and whether a received byte is answered with NAK.

Segment descriptors are stored outside the block. The sequencer drives `seg_sel`, and the parent answers with address, direction, length and a no-restart flag for that segment, combinationally in the same cycle. Write bytes arrive on a valid/ready input stream and read bytes leave on a valid/ready output stream. On the input stream a byte is taken only in a cycle where `wr_valid`, `wr_ready` and the engine's `cmd_ready` are all high; `wr_ready` already contains `cmd_ready`. On the output stream `rd_valid` stays high and `rd_data` stays stable until `rd_ready` is seen. The sequencer issues no further command while a read byte is waiting. The parent must hold `seg_count` and the descriptors stable while `busy` is high.

At the end, `done` pulses for one cycle. A result code and a count of completed segments are then held until the next launch.

Top module: `i2c_txn_seq`

## Requirements
- R1: A launch sends segment 0's address byte first, with START, as `cmd_byte = {addr7, rd}`. Any later segment that is not marked no-restart is also opened by its address byte with START, which is a repeated start.
- R2: Write data is taken from the input stream in order, one byte per accepted command. STOP is requested only on the last byte of the last segment.
- R3: Receive commands have `cmd_rx=1` and `cmd_byte=0`. Every receive command is ACKed, except the last byte of the last segment, which requests NAK and STOP together. Each received byte is offered on the output stream and held stable until it is accepted.
- R4: A no-restart segment (other than segment 0) sends no address byte. Its bytes follow directly in the direction of the previous segment, and its own read flag is ignored.
- R5: An event with bus error and NAK while the byte pointer and segment index are both zero ends the transaction with result 1 (retry). A bus error with NAK anywhere else ends it with result 2 (data NAK). A bus error without NAK ends it with result 3 (bus error).
- R6: A successful transaction ends with result 0 and `seg_done = seg_count`. A failed one reports the index of the segment in which it stopped.
- R7: An event with the arbitration-loss flag set is ignored entirely. The sequencer keeps waiting for the real outcome.
- R8: When the last segment has length zero, the transaction completes as soon as its address byte is acknowledged. `eng_reset` pulses in the same cycle as `done`.
- R9: After reset the block is idle with result 0 and count 0. `done` is a one-cycle pulse. `result` and `seg_done` hold until the next launch, and a launch while busy is ignored.
- R10: If no event arrives within `wd_limit` cycles (`wd_limit` of 1 or more) of a command being accepted, the transaction ends with result 4 (timeout).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch | input | 1 | Start a transaction (ignored while busy) |
| seg_count | input | SEG_W+1 | Number of segments, 1 or more |
| seg_sel | output | SEG_W | Index of the descriptor being read |
| desc_addr | input | 7 | Target address of the selected segment |
| desc_rd | input | 1 | Selected segment is a read |
| desc_len | input | LEN_W | Byte count of the selected segment |
| desc_nors | input | 1 | Selected segment continues without an address |
| wr_valid | input | 1 | Write byte available |
| wr_data | input | 8 | Write byte |
| wr_ready | output | 1 | Write byte taken this cycle |
| rd_valid | output | 1 | Read byte available |
| rd_data | output | 8 | Read byte |
| rd_ready | input | 1 | Consumer accepts the read byte |
| cmd_valid | output | 1 | Command to the byte engine |
| cmd_ready | input | 1 | Byte engine accepts the command |
| cmd_byte | output | 8 | Byte to send (0 for receive) |
| cmd_start | output | 1 | Generate START before the byte |
| cmd_stop | output | 1 | Generate STOP after the byte |
| cmd_nak | output | 1 | Answer the received byte with NAK |
| cmd_rx | output | 1 | Receive a byte instead of sending |
| ev_valid | input | 1 | Byte outcome from the engine |
| ev_nak | input | 1 | Peer did not acknowledge |
| ev_berr | input | 1 | Bus error on this byte |
| ev_arb | input | 1 | Arbitration-loss indication |
| ev_data | input | 8 | Received byte |
| wd_limit | input | WD_W | Event timeout in cycles |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 ok, 1 retry, 2 data NAK, 3 bus error, 4 timeout |
| seg_done | output | SEG_W+1 | Completed segment count |
| eng_reset | output | 1 | Reset request to the byte engine |

## Verification
Some rules hold on every cycle, and the assertions check those. START never appears together with STOP, NAK or receive. NAK is never requested without receive and STOP. A waiting read byte holds still under back-pressure. `done` lasts one cycle, and the result is frozen while idle. An engine reset comes only with a successful finish, and a successful finish reports the full segment count.

Other behaviour depends on the order of events, and only the bench scenarios can show it: the exact order of address, data, repeated START and no-restart continuation bytes, the choice between retry and data NAK, an arbitration indication being ignored, and the exact timeout cycle. The bench builds its expected command stream from the descriptors and compares every accepted command and every delivered read byte against it.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [2:0] {
    RES_OK       = 3'd0,
    RES_RETRY    = 3'd1,
    RES_DATA_NAK = 3'd2,
    RES_BUS_ERR  = 3'd3,
    RES_TIMEOUT  = 3'd4
  } res_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_DATA,
    S_WAIT,
    S_RDOUT,
    S_NEXT
  } st_e;

  typedef struct packed {
    logic       start;
    logic       stop;
    logic       nak;
    logic       rx;
    logic [7:0] bval;
  } cmd_t;

endpackage

// File: rtl/i2c_seq_cmd.sv
module i2c_seq_cmd
  import i2c_seq_pkg::*;
(
  input  logic       is_addr,
  input  logic [6:0] addr,
  input  logic       addr_rd,
  input  logic       rx,
  input  logic [7:0] wbyte,
  input  logic       fin_byte,
  output cmd_t       cmd
);
  // Address byte: START only. Data byte: STOP on the final byte of the
  // final segment, NAK added when that final byte is received.
  always_comb begin
    if (is_addr) begin
      cmd = '{start: 1'b1, stop: 1'b0, nak: 1'b0, rx: 1'b0, bval: {addr, addr_rd}};
    end else if (rx) begin
      cmd = '{start: 1'b0, stop: fin_byte, nak: fin_byte, rx: 1'b1, bval: 8'h00};
    end else begin
      cmd = '{start: 1'b0, stop: fin_byte, nak: 1'b0, rx: 1'b0, bval: wbyte};
    end
  end
endmodule

// File: rtl/i2c_seq_wd.sv
module i2c_seq_wd #(
  parameter int WD_W = 16
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            kick,
  input  logic [WD_W-1:0] limit,
  output logic            expire
);
  logic [WD_W-1:0] cnt;

  // Fires in the limit-th consecutive waiting cycle without an event.
  assign expire = run && !kick && (cnt == limit - WD_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || kick || expire) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + WD_W'(1);
    end
  end
endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq
  import i2c_seq_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int LEN_W = 8,
  parameter int WD_W  = 16,
  localparam int CNT_W = SEG_W + 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [CNT_W-1:0] seg_count,
  output logic [SEG_W-1:0] seg_sel,
  input  logic [6:0]       desc_addr,
  input  logic             desc_rd,
  input  logic [LEN_W-1:0] desc_len,
  input  logic             desc_nors,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  output logic             wr_ready,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  input  logic             rd_ready,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [7:0]       cmd_byte,
  output logic             cmd_start,
  output logic             cmd_stop,
  output logic             cmd_nak,
  output logic             cmd_rx,
  input  logic             ev_valid,
  input  logic             ev_nak,
  input  logic             ev_berr,
  input  logic             ev_arb,
  input  logic [7:0]       ev_data,
  input  logic [WD_W-1:0]  wd_limit,
  output logic             busy,
  output logic             done,
  output logic [2:0]       result,
  output logic [CNT_W-1:0] seg_done,
  output logic             eng_reset
);
  st_e              st;
  logic [SEG_W-1:0] seg;
  logic [LEN_W-1:0] ptr;
  logic             cur_rx;
  logic             in_addr;
  logic [7:0]       rd_q;
  logic             done_q, rst_q;
  res_e             res_q;
  logic [CNT_W-1:0] cnt_q;

  logic last_seg, last_byte, seg_empty, skip_addr;
  logic fire, ev_take, wd_exp;
  cmd_t cmd_w;

  assign last_seg  = ({1'b0, seg} == seg_count - CNT_W'(1));
  assign last_byte = (ptr == desc_len - LEN_W'(1));
  assign seg_empty = (ptr == desc_len);
  assign skip_addr = (seg != '0) && desc_nors;

  i2c_seq_cmd u_cmd (
    .is_addr  (st == S_ADDR),
    .addr     (desc_addr),
    .addr_rd  (desc_rd),
    .rx       (cur_rx),
    .wbyte    (wr_data),
    .fin_byte (last_byte && last_seg),
    .cmd      (cmd_w)
  );

  assign cmd_valid = ((st == S_ADDR) && !skip_addr) ||
                     ((st == S_DATA) && !seg_empty && (cur_rx || wr_valid));
  assign wr_ready  = (st == S_DATA) && !seg_empty && !cur_rx && cmd_ready;
  assign fire      = cmd_valid && cmd_ready;
  assign ev_take   = (st == S_WAIT) && ev_valid && !ev_arb;

  i2c_seq_wd #(.WD_W(WD_W)) u_wd (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (st == S_WAIT),
    .kick   (ev_take),
    .limit  (wd_limit),
    .expire (wd_exp)
  );

  // Completion decision
  logic             fin, fin_rst;
  res_e             fin_code;
  logic [CNT_W-1:0] fin_cnt;

  always_comb begin
    fin      = 1'b0;
    fin_rst  = 1'b0;
    fin_code = RES_OK;
    fin_cnt  = {1'b0, seg};
    if (st == S_WAIT) begin
      if (wd_exp) begin
        fin      = 1'b1;
        fin_code = RES_TIMEOUT;
      end else if (ev_take && ev_berr) begin
        fin = 1'b1;
        if (!ev_nak)                        fin_code = RES_BUS_ERR;
        else if (ptr == '0 && seg == '0)    fin_code = RES_RETRY;
        else                                fin_code = RES_DATA_NAK;
      end else if (ev_take && in_addr && desc_len == '0 && last_seg) begin
        fin     = 1'b1;
        fin_rst = 1'b1;
        fin_cnt = seg_count;
      end
    end else if (st == S_NEXT && last_seg) begin
      fin     = 1'b1;
      fin_cnt = seg_count;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      seg     <= '0;
      ptr     <= '0;
      cur_rx  <= 1'b0;
      in_addr <= 1'b0;
      rd_q    <= '0;
      done_q  <= 1'b0;
      rst_q   <= 1'b0;
      res_q   <= RES_OK;
      cnt_q   <= '0;
    end else begin
      done_q <= 1'b0;
      rst_q  <= 1'b0;
      if (fin) begin
        done_q <= 1'b1;
        rst_q  <= fin_rst;
        res_q  <= fin_code;
        cnt_q  <= fin_cnt;
        st     <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (launch) begin
            seg <= '0;
            ptr <= '0;
            st  <= S_ADDR;
          end
          S_ADDR: begin
            if (skip_addr) begin
              st <= S_DATA;
            end else if (fire) begin
              cur_rx  <= desc_rd;
              in_addr <= 1'b1;
              st      <= S_WAIT;
            end
          end
          S_DATA: begin
            if (seg_empty) begin
              st <= S_NEXT;
            end else if (fire) begin
              ptr     <= ptr + LEN_W'(1);
              in_addr <= 1'b0;
              st      <= S_WAIT;
            end
          end
          S_WAIT: if (ev_take) begin
            if (!in_addr && cur_rx) begin
              rd_q <= ev_data;
              st   <= S_RDOUT;
            end else begin
              st <= S_DATA;
            end
          end
          S_RDOUT: if (rd_ready) st <= S_DATA;
          S_NEXT: begin
            seg <= seg + SEG_W'(1);
            ptr <= '0;
            st  <= S_ADDR;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign seg_sel   = seg;
  assign cmd_byte  = cmd_w.bval;
  assign cmd_start = cmd_w.start;
  assign cmd_stop  = cmd_w.stop;
  assign cmd_nak   = cmd_w.nak;
  assign cmd_rx    = cmd_w.rx;
  assign rd_valid  = (st == S_RDOUT);
  assign rd_data   = rd_q;
  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign eng_reset = rst_q;
  assign result    = res_q;
  assign seg_done  = cnt_q;
endmodule

// File: rtl/i2c_txn_seq_chk.sv
module i2c_txn_seq_chk #(
  parameter int SEG_W = 3
)(
  input logic             clk,
  input logic             rst_n,
  input logic             launch,
  input logic [SEG_W:0]   seg_count,
  input logic             busy,
  input logic             done,
  input logic [2:0]       result,
  input logic [SEG_W:0]   seg_done,
  input logic             eng_reset,
  input logic             cmd_valid,
  input logic             cmd_start,
  input logic             cmd_stop,
  input logic             cmd_nak,
  input logic             cmd_rx,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [7:0]       rd_data
);
  assert_addr_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_start |-> !cmd_stop && !cmd_nak && !cmd_rx);

  assert_nak_final_rx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_nak |-> cmd_rx && cmd_stop);

  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  assert_ok_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && result == 3'd0 |-> seg_done == seg_count);

  assert_reset_on_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_reset |-> done && result == 3'd0);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_result_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !launch |=> $stable(result) && $stable(seg_done));
endmodule

bind i2c_txn_seq i2c_txn_seq_chk #(.SEG_W(SEG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .launch    (launch),
  .seg_count (seg_count),
  .busy      (busy),
  .done      (done),
  .result    (result),
  .seg_done  (seg_done),
  .eng_reset (eng_reset),
  .cmd_valid (cmd_valid),
  .cmd_start (cmd_start),
  .cmd_stop  (cmd_stop),
  .cmd_nak   (cmd_nak),
  .cmd_rx    (cmd_rx),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data)
);

// File: tb/i2c_txn_seq_bench.sv
`timescale 1ns/1ps
module i2c_txn_seq_bench;
  localparam int SEG_W = 3;
  localparam int LEN_W = 8;
  localparam int WD_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             launch = 1'b0;
  logic [SEG_W:0]   seg_count = 4'd1;
  logic [SEG_W-1:0] seg_sel;
  logic [6:0]       desc_addr;
  logic             desc_rd, desc_nors;
  logic [LEN_W-1:0] desc_len;
  logic             wr_valid = 1'b0;
  logic [7:0]       wr_data = 8'h00;
  logic             wr_ready;
  logic             rd_valid;
  logic [7:0]       rd_data;
  logic             rd_ready = 1'b0;
  logic             cmd_valid;
  logic             cmd_ready = 1'b0;
  logic [7:0]       cmd_byte;
  logic             cmd_start, cmd_stop, cmd_nak, cmd_rx;
  logic             ev_valid = 1'b0, ev_nak = 1'b0, ev_berr = 1'b0, ev_arb = 1'b0;
  logic [7:0]       ev_data = 8'h00;
  logic [WD_W-1:0]  wd_limit = 16'd40;
  logic             busy, done, eng_reset;
  logic [2:0]       result;
  logic [SEG_W:0]   seg_done;

  logic [6:0] d_addr [8];
  logic       d_rd   [8];
  logic [7:0] d_len  [8];
  logic       d_nors [8];

  assign desc_addr = d_addr[seg_sel];
  assign desc_rd   = d_rd[seg_sel];
  assign desc_len  = d_len[seg_sel];
  assign desc_nors = d_nors[seg_sel];

  i2c_txn_seq #(.SEG_W(SEG_W), .LEN_W(LEN_W), .WD_W(WD_W)) u_i2c_txn_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .seg_count(seg_count),
    .seg_sel(seg_sel), .desc_addr(desc_addr), .desc_rd(desc_rd),
    .desc_len(desc_len), .desc_nors(desc_nors),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_byte(cmd_byte),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_nak(cmd_nak), .cmd_rx(cmd_rx),
    .ev_valid(ev_valid), .ev_nak(ev_nak), .ev_berr(ev_berr), .ev_arb(ev_arb),
    .ev_data(ev_data), .wd_limit(wd_limit),
    .busy(busy), .done(done), .result(result), .seg_done(seg_done),
    .eng_reset(eng_reset)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference model state
  logic [11:0] exp_cmd [$];
  logic [7:0]  wr_q    [$];
  logic [7:0]  exp_rd  [$];
  string scen_req = "R1";
  int  nak_at = -1, berr_at = -1, mute_at = -1, arb_at = -1;
  int  k_cmd = 0;
  bit  pend = 0, pend_rx = 0, arb_sent = 0;
  int  pend_dly = 0, pend_k = 0;
  int  cyc = 0, cyc_acc = 0, cyc_done = 0;
  bit  got_done = 0, got_rst = 0;
  int  done_pulses = 0;
  logic [2:0] got_res = 3'd0;
  logic [SEG_W:0] got_cnt = '0;
  bit  engine_on = 0;

  // Byte engine and per-clock comparison
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (engine_on) begin
        cmd_ready = (cyc % 3) != 1;
        rd_ready  = (cyc % 4) != 2;
        if (wr_q.size() > 0) begin
          wr_valid = 1'b1;
          wr_data  = wr_q[0];
        end else begin
          wr_valid = 1'b0;
        end
        ev_valid = 0; ev_arb = 0; ev_nak = 0; ev_berr = 0;
        if (pend) begin
          if (pend_dly > 0) begin
            pend_dly--;
          end else if (arb_at == pend_k && !arb_sent) begin
            ev_valid = 1; ev_arb = 1; ev_nak = 1; ev_berr = 1;
            arb_sent = 1;
            pend_dly = 3;
          end else begin
            ev_valid = 1;
            ev_nak   = (pend_k == nak_at);
            ev_berr  = (pend_k == nak_at) || (pend_k == berr_at);
            ev_data  = 8'h3C ^ pend_k[7:0];
            if (pend_rx && !ev_berr) exp_rd.push_back(ev_data);
            pend = 0;
          end
        end
        #1;
        if (cmd_valid && cmd_ready) begin
          logic [11:0] got;
          got = {cmd_start, cmd_stop, cmd_nak, cmd_rx, cmd_byte};
          if (exp_cmd.size() == 0) begin
            chk(0, scen_req, "unexpected command", int'(got), 0);
          end else begin
            logic [11:0] e;
            e = exp_cmd.pop_front();
            chk(got == e, scen_req, "command {start,stop,nak,rx,byte}", int'(got), int'(e));
          end
          if (k_cmd != mute_at) begin
            pend = 1; pend_dly = 1; pend_k = k_cmd; pend_rx = cmd_rx;
          end
          cyc_acc = cyc;
          k_cmd++;
        end
        if (wr_valid && wr_ready) void'(wr_q.pop_front());
        if (rd_valid && rd_ready) begin
          if (exp_rd.size() == 0) chk(0, "R3", "unexpected read byte", int'(rd_data), 0);
          else begin
            logic [7:0] er;
            er = exp_rd.pop_front();
            chk(rd_data == er, "R3", "read byte", int'(rd_data), int'(er));
          end
        end
        if (done) begin
          got_done = 1; got_res = result; got_cnt = seg_done;
          got_rst = eng_reset; done_pulses++; cyc_done = cyc;
        end
      end
    end
  end

  // Expected command stream for a fully successful transaction
  task automatic build(input int n);
    bit dir;
    logic [7:0] wdat;
    dir = 0;
    wdat = 8'h10;
    exp_cmd.delete(); wr_q.delete(); exp_rd.delete();
    for (int s = 0; s < n; s++) begin
      if (s == 0 || !d_nors[s]) begin
        exp_cmd.push_back({1'b1, 1'b0, 1'b0, 1'b0, d_addr[s], d_rd[s]});
        dir = d_rd[s];
      end
      for (int b = 0; b < int'(d_len[s]); b++) begin
        bit last;
        last = (b == int'(d_len[s]) - 1) && (s == n - 1);
        if (dir) exp_cmd.push_back({1'b0, last, last, 1'b1, 8'h00});
        else begin
          wr_q.push_back(wdat);
          exp_cmd.push_back({1'b0, last, 1'b0, 1'b0, wdat});
          wdat = wdat + 8'h11;
        end
      end
    end
  endtask

  task automatic set_seg(input int s, input logic [6:0] a, input bit rd,
                         input int len, input bit nors);
    d_addr[s] = a; d_rd[s] = rd; d_len[s] = 8'(len); d_nors[s] = nors;
  endtask

  task automatic run(input int n, input int ex_res, input int ex_cnt,
                     input bit ex_rst, input bit mid_go, input string req);
    int w;
    seg_count = 4'(n);
    build(n);
    scen_req = req;
    k_cmd = 0; pend = 0; arb_sent = 0;
    got_done = 0; done_pulses = 0; got_rst = 0;
    @(negedge clk); launch = 1;
    @(negedge clk); launch = 0;
    if (mid_go) begin
      repeat (6) @(negedge clk);
      launch = 1;
      @(negedge clk); launch = 0;
    end
    w = 0;
    while (!got_done && w < 5000) begin
      @(negedge clk);
      w++;
    end
    chk(got_done, req, "done seen", int'(got_done), 1);
    repeat (4) @(negedge clk);
    chk(got_res == 3'(ex_res), req, "result", int'(got_res), ex_res);
    chk(got_cnt == 4'(ex_cnt), "R6", "seg_done", int'(got_cnt), ex_cnt);
    chk(got_rst == ex_rst, "R8", "eng_reset with done", int'(got_rst), int'(ex_rst));
    chk(done_pulses == 1, "R9", "done pulse count", done_pulses, 1);
    chk(result == got_res && !busy, "R9", "result held while idle", int'(result), int'(got_res));
    if (ex_res == 0) begin
      chk(exp_cmd.size() == 0, req, "commands left", exp_cmd.size(), 0);
      chk(wr_q.size() == 0, "R2", "write bytes left", wr_q.size(), 0);
      chk(exp_rd.size() == 0, "R3", "read bytes left", exp_rd.size(), 0);
    end
    exp_cmd.delete(); wr_q.delete(); exp_rd.delete();
    pend = 0;
    nak_at = -1; berr_at = -1; mute_at = -1; arb_at = -1;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) set_seg(i, 7'h00, 0, 0, 0);
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!busy && !done && !cmd_valid && !rd_valid, "R9", "idle after reset",
        int'({busy, done, cmd_valid, rd_valid}), 0);
    chk(result == 3'd0 && seg_done == '0, "R9", "reset result/count",
        int'({result, seg_done}), 0);
    engine_on = 1;

    // R1 R2: single write segment
    set_seg(0, 7'h50, 0, 3, 0);
    run(1, 0, 1, 0, 0, "R1");

    // R3 R4: write then read with repeated start
    set_seg(0, 7'h21, 0, 2, 0);
    set_seg(1, 7'h21, 1, 3, 0);
    run(2, 0, 2, 0, 0, "R3");

    // R4: no-restart continuation keeps write direction despite read flag
    set_seg(0, 7'h33, 0, 1, 0);
    set_seg(1, 7'h44, 1, 2, 1);
    set_seg(2, 7'h33, 1, 1, 0);
    run(3, 0, 3, 0, 0, "R4");

    // R8: zero-length probe
    set_seg(0, 7'h0A, 0, 0, 0);
    run(1, 0, 1, 1, 0, "R8");

    // R5: NAK on first address -> retry
    set_seg(0, 7'h50, 0, 3, 0);
    nak_at = 0;
    run(1, 1, 0, 0, 0, "R5");

    // R5: NAK on second segment's address -> data NAK, one segment done
    set_seg(0, 7'h21, 0, 2, 0);
    set_seg(1, 7'h21, 1, 3, 0);
    nak_at = 3;
    run(2, 2, 1, 0, 0, "R5");

    // R5: bus error without NAK
    set_seg(0, 7'h50, 0, 3, 0);
    berr_at = 1;
    run(1, 3, 0, 0, 0, "R5");

    // R7 R9: arbitration indication ignored; launch while busy ignored
    set_seg(0, 7'h21, 0, 2, 0);
    set_seg(1, 7'h21, 1, 3, 0);
    arb_at = 1;
    run(2, 0, 2, 0, 1, "R7");

    // R10: silent engine -> timeout in exactly wd_limit waiting cycles
    mute_at = 3;
    run(2, 4, 1, 0, 0, "R10");
    chk(cyc_done - cyc_acc == int'(wd_limit) + 1, "R10", "timeout latency",
        cyc_done - cyc_acc, int'(wd_limit) + 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule